// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each accepted operation takes the accumulator value, a second 8-bit operand and the flag byte the block itself holds. It produces an 8-bit result, a write-enable for that result and a new flag byte. The operations are add and subtract, each with and without carry, AND/OR/XOR, compare, increment and decrement, complement, four single-bit rotates, carry set and carry complement, and decimal adjust after a BCD addition. A 16-bit add of a register pair into the pointer pair uses the same block.

The sequencer presents an operation with `op_valid` high for one cycle. All outputs are registered. They appear together one clock later, marked by `res_valid`. The flag register holds its value between operations. Each operation changes only the flag bits that it is defined to touch. Register-file access and instruction sequencing are outside this block.

Top module: `acc_alu_flags`

## Requirements
- R1: The flag byte `flags_out` holds sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0. After reset, `flags_out` is 8'h00 and `res_valid` is 0.
- R2: An operation sampled with `op_valid` high delivers `res_valid`=1 and all its results on the next clock. A cycle without `op_valid` gives `res_valid`=0 on the next clock and leaves the flags unchanged.
- R3: Add (code 0), add-with-carry (1), subtract (2) and subtract-with-borrow (3) update all five flags. Carry is the carry out on add and the borrow on subtract. Auxiliary carry is the carry out of, or the borrow from, the low nibble. Parity is 1 when the result has an even number of one bits. Zero and sign follow the result.
- R4: Increment (8) and decrement (9) set sign, zero, parity and auxiliary carry from the result. Auxiliary carry comes from the low-nibble carry or borrow. The carry flag keeps its previous value.
- R5: AND (4) clears carry and sets auxiliary carry to the OR of bit 3 of both operands. XOR (5) and OR (6) clear both carry and auxiliary carry. All three set sign, zero and parity from the result.
- R6: Compare (7) sets the flags exactly as subtract does, and its `res_we` is 0.
- R7: Rotate-left-circular (11) moves bit 7 into carry and into bit 0. Rotate-right-circular (12) moves bit 0 into carry and into bit 7. Rotate-left-through-carry (13) moves bit 7 into carry and the old carry into bit 0. Rotate-right-through-carry (14) moves bit 0 into carry and the old carry into bit 7. Rotates change only the carry flag.
- R8: Complement-carry (15) inverts carry and set-carry (16) sets carry; both have `res_we`=0 and change no other flag. Complement (10) outputs the inverted accumulator with `res_we`=1 and leaves all flags unchanged.
- R9: Decimal adjust (17) works in two steps. It adds 06h when the low nibble exceeds 9 or auxiliary carry is set. It then adds 60h when the high nibble of that sum exceeds 9, when that sum carried out, or when carry is set. Carry becomes 1 when the second correction is applied. Auxiliary carry is the low-nibble carry of the first correction. Sign, zero and parity follow the result.
- R10: Pair add (18) outputs `pair_dst_in`+`pair_src_in` modulo 2^16 on `wide_out` with `wide_we`=1 and `res_we`=0. Carry takes the carry out of bit 15, and no other flag changes.
- R11: Codes 19 to 31 are unassigned. They still give `res_valid`, but with `res_we`=0 and `wide_we`=0, and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second 8-bit operand |
| pair_dst_in | input | 16 | Pointer pair, first addend of pair add |
| pair_src_in | input | 16 | Register pair, second addend of pair add |
| res_valid | output | 1 | Results of the previous cycle's operation are present |
| res_out | output | 8 | 8-bit result |
| res_we | output | 1 | 8-bit result is to be written back |
| wide_out | output | 16 | 16-bit pair-add result |
| wide_we | output | 1 | 16-bit result is to be written back |
| flags_out | output | 8 | Flag register |

## Verification
Each result, its write-enables and the updated flag byte are due on the first clock edge after the edge that samples `op_valid`. Nothing in the block has a longer path. The driver computes the expected item for each operation and queues it in the cycle it presents the operation. The monitor samples one nanosecond after each rising edge and pops one item for every `res_valid` it sees, so each comparison lands in exactly the cycle its result is due. Idle gaps are checked for an unchanged flag byte and a low `res_valid`, and operations that must leave flags alone are placed after ones that set them to a non-zero pattern.

// File: rtl/aluf_pkg.sv
package aluf_pkg;
   localparam int ALUF_OP_W = 5;

   typedef enum logic [ALUF_OP_W-1:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBB  = 5'd3,
      OP_AND  = 5'd4,
      OP_XOR  = 5'd5,
      OP_OR   = 5'd6,
      OP_CMP  = 5'd7,
      OP_INC  = 5'd8,
      OP_DEC  = 5'd9,
      OP_CPL  = 5'd10,
      OP_RLC  = 5'd11,
      OP_RRC  = 5'd12,
      OP_RAL  = 5'd13,
      OP_RAR  = 5'd14,
      OP_CMC  = 5'd15,
      OP_STC  = 5'd16,
      OP_DAA  = 5'd17,
      OP_DADP = 5'd18
   } aluf_op_e;

   // flag byte bit positions
   localparam int FLG_CY   = 0;
   localparam int FLG_PAR  = 2;
   localparam int FLG_AUX  = 4;
   localparam int FLG_ZERO = 6;
   localparam int FLG_SIGN = 7;
   localparam int FLG_W    = 8;
endpackage

// File: rtl/aluf_parity.sv
module aluf_parity #(
   parameter int W    = 8,
   parameter int IMPL = 0   // 0: reduction operator, 1: explicit xor chain
) (
   input  logic [W-1:0] din,
   output logic         even
);
   generate
      if (W < 1) begin : g_bad_w
         $error("aluf_parity: W must be at least 1");
      end
      if (IMPL == 0) begin : g_reduce
         assign even = ~^din;
      end else begin : g_chain
         logic [W:0] acc_x;
         assign acc_x[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign acc_x[i+1] = acc_x[i] ^ din[i];
         end
         assign even = ~acc_x[W];
      end
   endgenerate
endmodule

// File: rtl/aluf_arith.sv
module aluf_arith
   import aluf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [ALUF_OP_W-1:0] op,
   input  logic [DATA_W-1:0]    a,
   input  logic [DATA_W-1:0]    b,
   input  logic                 cy_in,
   input  logic                 ac_in,
   input  logic [2*DATA_W-1:0]  pair_a,
   input  logic [2*DATA_W-1:0]  pair_b,
   output logic [DATA_W-1:0]    res,
   output logic                 cy_out,
   output logic                 ac_out,
   output logic [2*DATA_W-1:0]  pair_sum,
   output logic                 pair_cy
);
   localparam int NIB    = DATA_W / 2;
   localparam int PAIR_W = 2 * DATA_W;
   localparam logic [DATA_W-1:0] LO_CORR = DATA_W'(6);
   localparam logic [DATA_W-1:0] HI_CORR = DATA_W'(6) << NIB;
   localparam logic [NIB-1:0]    DIG_MAX = NIB'(9);

   logic              cin;
   logic [DATA_W:0]   full_s;
   logic [NIB:0]      nib_s;
   logic [DATA_W:0]   daa_t;
   logic              lo_fix;
   logic              hi_fix;
   logic [PAIR_W:0]   pair_full;

   assign cin = ((op == OP_ADC) || (op == OP_SBB)) ? cy_in : 1'b0;

   always_comb begin
      res    = '0;
      cy_out = 1'b0;
      ac_out = 1'b0;
      full_s = '0;
      nib_s  = '0;
      daa_t  = '0;
      lo_fix = 1'b0;
      hi_fix = 1'b0;
      case (op)
         OP_ADD, OP_ADC: begin
            full_s = {1'b0, a} + {1'b0, b} + (DATA_W+1)'(cin);
            nib_s  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + (NIB+1)'(cin);
            res    = full_s[DATA_W-1:0];
            cy_out = full_s[DATA_W];
            ac_out = nib_s[NIB];
         end
         OP_SUB, OP_SBB, OP_CMP: begin
            full_s = {1'b0, a} - {1'b0, b} - (DATA_W+1)'(cin);
            nib_s  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - (NIB+1)'(cin);
            res    = full_s[DATA_W-1:0];
            cy_out = full_s[DATA_W];
            ac_out = nib_s[NIB];
         end
         OP_INC: begin
            res    = a + DATA_W'(1);
            cy_out = cy_in;
            ac_out = &a[NIB-1:0];
         end
         OP_DEC: begin
            res    = a - DATA_W'(1);
            cy_out = cy_in;
            ac_out = ~|a[NIB-1:0];
         end
         OP_DAA: begin
            lo_fix = (a[NIB-1:0] > DIG_MAX) || ac_in;
            daa_t  = {1'b0, a} + {1'b0, (lo_fix ? LO_CORR : '0)};
            nib_s  = {1'b0, a[NIB-1:0]} + {1'b0, (lo_fix ? LO_CORR[NIB-1:0] : '0)};
            hi_fix = (daa_t[DATA_W-1:NIB] > DIG_MAX) || daa_t[DATA_W] || cy_in;
            res    = daa_t[DATA_W-1:0] + (hi_fix ? HI_CORR : '0);
            cy_out = hi_fix;
            ac_out = nib_s[NIB];
         end
         default: begin
            res    = a;
            cy_out = cy_in;
         end
      endcase
   end

   assign pair_full = {1'b0, pair_a} + {1'b0, pair_b};
   assign pair_sum  = pair_full[PAIR_W-1:0];
   assign pair_cy   = pair_full[PAIR_W];
endmodule

// File: rtl/aluf_logic.sv
module aluf_logic
   import aluf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [ALUF_OP_W-1:0] op,
   input  logic [DATA_W-1:0]    a,
   input  logic [DATA_W-1:0]    b,
   input  logic                 cy_in,
   output logic [DATA_W-1:0]    res,
   output logic                 cy_out,
   output logic                 ac_out
);
   localparam int NIB = DATA_W / 2;
   localparam int MSB = DATA_W - 1;

   always_comb begin
      res    = a;
      cy_out = cy_in;
      ac_out = 1'b0;
      case (op)
         OP_AND: begin
            res    = a & b;
            cy_out = 1'b0;
            ac_out = a[NIB-1] | b[NIB-1];
         end
         OP_XOR: begin
            res    = a ^ b;
            cy_out = 1'b0;
         end
         OP_OR: begin
            res    = a | b;
            cy_out = 1'b0;
         end
         OP_CPL: res = ~a;
         OP_RLC: begin
            res    = {a[MSB-1:0], a[MSB]};
            cy_out = a[MSB];
         end
         OP_RRC: begin
            res    = {a[0], a[MSB:1]};
            cy_out = a[0];
         end
         OP_RAL: begin
            res    = {a[MSB-1:0], cy_in};
            cy_out = a[MSB];
         end
         OP_RAR: begin
            res    = {cy_in, a[MSB:1]};
            cy_out = a[0];
         end
         OP_CMC: cy_out = ~cy_in;
         OP_STC: cy_out = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
   import aluf_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PAR_IMPL = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic [4:0]           op_code,
   input  logic [DATA_W-1:0]    acc_in,
   input  logic [DATA_W-1:0]    opnd_in,
   input  logic [2*DATA_W-1:0]  pair_dst_in,
   input  logic [2*DATA_W-1:0]  pair_src_in,
   output logic                 res_valid,
   output logic [DATA_W-1:0]    res_out,
   output logic                 res_we,
   output logic [2*DATA_W-1:0]  wide_out,
   output logic                 wide_we,
   output logic [FLG_W-1:0]     flags_out
);
   localparam int PAIR_W = 2 * DATA_W;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("acc_alu_flags: flag layout requires DATA_W == 8");
      end
      if ((PAR_IMPL != 0) && (PAR_IMPL != 1)) begin : g_bad_par
         $error("acc_alu_flags: PAR_IMPL must be 0 or 1");
      end
   endgenerate

   logic [FLG_W-1:0]  flags_q;
   logic [DATA_W-1:0] ar_res, lg_res, sel_res;
   logic              ar_cy, ar_ac, lg_cy, lg_ac;
   logic [PAIR_W-1:0] pr_sum;
   logic              pr_cy;
   logic              par_even;
   logic              use_arith;

   aluf_arith #(.DATA_W(DATA_W)) arith_i (
      .op(op_code), .a(acc_in), .b(opnd_in),
      .cy_in(flags_q[FLG_CY]), .ac_in(flags_q[FLG_AUX]),
      .pair_a(pair_dst_in), .pair_b(pair_src_in),
      .res(ar_res), .cy_out(ar_cy), .ac_out(ar_ac),
      .pair_sum(pr_sum), .pair_cy(pr_cy)
   );

   aluf_logic #(.DATA_W(DATA_W)) logic_i (
      .op(op_code), .a(acc_in), .b(opnd_in), .cy_in(flags_q[FLG_CY]),
      .res(lg_res), .cy_out(lg_cy), .ac_out(lg_ac)
   );

   always_comb begin
      case (op_code)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP,
         OP_INC, OP_DEC, OP_DAA: use_arith = 1'b1;
         default:                use_arith = 1'b0;
      endcase
   end

   assign sel_res = use_arith ? ar_res : lg_res;

   aluf_parity #(.W(DATA_W), .IMPL(PAR_IMPL)) parity_i (
      .din(sel_res), .even(par_even)
   );

   function automatic logic [FLG_W-1:0] pack_flags(
      input logic s, input logic z, input logic ac, input logic p, input logic c);
      logic [FLG_W-1:0] f;
      f = '0;
      f[FLG_SIGN] = s;
      f[FLG_ZERO] = z;
      f[FLG_AUX]  = ac;
      f[FLG_PAR]  = p;
      f[FLG_CY]   = c;
      return f;
   endfunction

   logic [FLG_W-1:0] n_flags;
   logic             n_we, n_wwe;
   logic             res_sign, res_zero;

   assign res_sign = sel_res[DATA_W-1];
   assign res_zero = (sel_res == '0);

   always_comb begin
      n_flags = flags_q;
      n_we    = 1'b0;
      n_wwe   = 1'b0;
      case (op_code)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_DAA: begin
            n_flags = pack_flags(res_sign, res_zero, ar_ac, par_even, ar_cy);
            n_we    = 1'b1;
         end
         OP_CMP:
            n_flags = pack_flags(res_sign, res_zero, ar_ac, par_even, ar_cy);
         OP_INC, OP_DEC: begin
            n_flags = pack_flags(res_sign, res_zero, ar_ac, par_even, flags_q[FLG_CY]);
            n_we    = 1'b1;
         end
         OP_AND, OP_XOR, OP_OR: begin
            n_flags = pack_flags(res_sign, res_zero, lg_ac, par_even, lg_cy);
            n_we    = 1'b1;
         end
         OP_CPL: n_we = 1'b1;
         OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
            n_flags[FLG_CY] = lg_cy;
            n_we            = 1'b1;
         end
         OP_CMC, OP_STC: n_flags[FLG_CY] = lg_cy;
         OP_DADP: begin
            n_flags[FLG_CY] = pr_cy;
            n_wwe           = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_out   <= '0;
         res_we    <= 1'b0;
         wide_out  <= '0;
         wide_we   <= 1'b0;
         flags_q   <= '0;
      end else begin
         res_valid <= op_valid;
         if (op_valid) begin
            res_out  <= sel_res;
            res_we   <= n_we;
            wide_out <= pr_sum;
            wide_we  <= n_wwe;
            flags_q  <= n_flags;
         end
      end
   end

   assign flags_out = flags_q;

   // assertions beside the flag register
   AST_UNUSED_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_out[5] == 1'b0) && (flags_out[3] == 1'b0) && (flags_out[1] == 1'b0)); // R1

   AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!res_valid && $stable(flags_out))); // R2

   AST_INCDEC_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && ((op_code == OP_INC) || (op_code == OP_DEC)))
      |=> (flags_out[FLG_CY] == $past(flags_out[FLG_CY]))); // R4

   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_CMP)) |=> (res_valid && !res_we)); // R6

   AST_RLC_CARRY_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_RLC)) |=> (res_out[0] == flags_out[FLG_CY])); // R7

   AST_PAIR_ONLY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_DADP))
      |=> (wide_we && !res_we && (flags_out[FLG_W-1:1] == $past(flags_out[FLG_W-1:1])))); // R10

   AST_UNASSIGNED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code > OP_DADP)) |=> (!res_we && !wide_we && $stable(flags_out))); // R11
endmodule

// File: tb/acc_alu_flags_tb_top.sv
`timescale 1ns/1ps
module acc_alu_flags_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [4:0]  op_code = '0;
   logic [7:0]  acc_in = '0, opnd_in = '0;
   logic [15:0] pair_dst_in = '0, pair_src_in = '0;
   logic        res_valid, res_we, wide_we;
   logic [7:0]  res_out, flags_out;
   logic [15:0] wide_out;

   always #2 clk = ~clk;

   acc_alu_flags dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .acc_in(acc_in), .opnd_in(opnd_in), .pair_dst_in(pair_dst_in),
      .pair_src_in(pair_src_in), .res_valid(res_valid), .res_out(res_out),
      .res_we(res_we), .wide_out(wide_out), .wide_we(wide_we), .flags_out(flags_out)
   );

   typedef struct packed {
      logic [7:0]  res;
      logic        we;
      logic [15:0] wide;
      logic        wwe;
      logic [7:0]  flags;
   } exp_t;

   exp_t   exp_q[$];
   string  tag_q[$];
   int     checks = 0;
   int     errors = 0;
   logic [7:0] mflags = 8'h00;
   bit     done = 1'b0;

   function automatic int even_par(input int v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += (v >> i) & 1;
      return ((n % 2) == 0) ? 1 : 0;
   endfunction

   function automatic exp_t model(input int op, input int a, input int b,
                                  input int hl, input int rp, input logic [7:0] f);
      exp_t e;
      int cy = f[0];
      int ac = f[4];
      int r = a, nc = cy, nac = 0, s = 0, ci = 0, t = 0;
      int mode = 0; // 0 none, 1 all flags, 2 carry only
      e = '0;
      case (op)
         0, 1: begin
            ci = (op == 1) ? cy : 0;
            s = a + b + ci; r = s & 255; nc = (s > 255);
            nac = (((a & 15) + (b & 15) + ci) > 15); mode = 1; e.we = 1;
         end
         2, 3, 7: begin
            ci = (op == 3) ? cy : 0;
            s = a - b - ci; r = s & 255; nc = (s < 0);
            nac = (((a & 15) - (b & 15) - ci) < 0); mode = 1; e.we = (op != 7);
         end
         8: begin r = (a + 1) & 255; nac = ((a & 15) == 15); mode = 1; e.we = 1; end
         9: begin r = (a - 1) & 255; nac = ((a & 15) == 0);  mode = 1; e.we = 1; end
         4: begin r = a & b; nac = ((a >> 3) & 1) | ((b >> 3) & 1); nc = 0; mode = 1; e.we = 1; end
         5: begin r = a ^ b; nc = 0; mode = 1; e.we = 1; end
         6: begin r = a | b; nc = 0; mode = 1; e.we = 1; end
         10: begin r = 255 - a; e.we = 1; end
         11: begin r = ((a << 1) | (a >> 7)) & 255; nc = a >> 7; mode = 2; e.we = 1; end
         12: begin r = (a >> 1) | ((a & 1) << 7); nc = a & 1; mode = 2; e.we = 1; end
         13: begin r = ((a << 1) | cy) & 255; nc = a >> 7; mode = 2; e.we = 1; end
         14: begin r = (a >> 1) | (cy << 7); nc = a & 1; mode = 2; e.we = 1; end
         15: begin nc = 1 - cy; mode = 2; end
         16: begin nc = 1; mode = 2; end
         17: begin
            ci = (((a & 15) > 9) || ac) ? 6 : 0;
            nac = (((a & 15) + ci) > 15);
            t = a + ci;
            if ((((t >> 4) & 15) > 9) || (t > 255) || cy) begin
               nc = 1; t = t + 96;
            end else nc = 0;
            r = t & 255; mode = 1; e.we = 1;
         end
         18: begin
            s = hl + rp; e.wide = 16'(s & 65535); nc = (s > 65535); mode = 2; e.wwe = 1;
         end
         default: ;
      endcase
      e.res = 8'(r);
      if (mode == 1)
         e.flags = {1'(r >> 7), 1'(r == 0), 1'b0, 1'(nac), 1'b0, 1'(even_par(r)), 1'b0, 1'(nc)};
      else if (mode == 2)
         e.flags = {f[7:1], 1'(nc)};
      else
         e.flags = f;
      return e;
   endfunction

   task automatic run_op(input int op, input int a, input int b,
                         input int hl, input int rp, input string tag);
      exp_t e;
      @(negedge clk);
      op_valid    = 1'b1;
      op_code     = 5'(op);
      acc_in      = 8'(a);
      opnd_in     = 8'(b);
      pair_dst_in = 16'(hl);
      pair_src_in = 16'(rp);
      e = model(op, a, b, hl, rp, mflags);
      mflags = e.flags;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic go_idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         op_valid = 1'b0;
      end
   endtask

   // scoreboard monitor: results are due one edge after the op is sampled
   initial begin
      exp_t  e;
      string tg;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && res_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R2: unexpected res_valid, actual=1 expected=0");
            end else begin
               e  = exp_q.pop_front();
               tg = tag_q.pop_front();
               if ((flags_out !== e.flags) || (res_we !== e.we) || (wide_we !== e.wwe) ||
                   (e.we && (res_out !== e.res)) || (e.wwe && (wide_out !== e.wide))) begin
                  errors++;
                  $display("FAIL %s: actual res=%h we=%b wide=%h wwe=%b flags=%h expected res=%h we=%b wide=%h wwe=%b flags=%h",
                           tg, res_out, res_we, wide_out, wide_we, flags_out,
                           e.res, e.we, e.wide, e.wwe, e.flags);
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2: watchdog expired, actual=hung expected=complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check_idle(input string tag);
      checks++;
      if (res_valid !== 1'b0 || flags_out !== mflags) begin
         errors++;
         $display("FAIL %s: actual res_valid=%b flags=%h expected res_valid=0 flags=%h",
                  tag, res_valid, flags_out, mflags);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      checks++;
      if (flags_out !== 8'h00 || res_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: reset actual flags=%h valid=%b expected flags=00 valid=0",
                  flags_out, res_valid);
      end
      @(negedge clk);
      rst_n = 1'b1;
      go_idle(2);

      // R3 add/subtract family
      run_op(0, 8'h45, 8'h38, 0, 0, "R3");
      run_op(0, 8'hFF, 8'h01, 0, 0, "R3");
      run_op(1, 8'h10, 8'h20, 0, 0, "R3");
      run_op(2, 8'h10, 8'h20, 0, 0, "R3");
      run_op(3, 8'h05, 8'h04, 0, 0, "R3");
      run_op(2, 8'h7A, 8'h7A, 0, 0, "R3");
      run_op(1, 8'h7F, 8'h00, 0, 0, "R3");
      // R4 increment / decrement keep carry
      run_op(16, 0, 0, 0, 0, "R8");
      run_op(8, 8'hFF, 0, 0, 0, "R4");
      run_op(8, 8'h0F, 0, 0, 0, "R4");
      run_op(15, 0, 0, 0, 0, "R8");
      run_op(9, 8'h00, 0, 0, 0, "R4");
      run_op(9, 8'h01, 0, 0, 0, "R4");
      // R5 logic
      run_op(16, 0, 0, 0, 0, "R8");
      run_op(4, 8'h0F, 8'h08, 0, 0, "R5");
      run_op(4, 8'hF0, 8'h07, 0, 0, "R5");
      run_op(16, 0, 0, 0, 0, "R8");
      run_op(6, 8'hF0, 8'h0F, 0, 0, "R5");
      run_op(5, 8'h5A, 8'h5A, 0, 0, "R5");
      run_op(5, 8'h80, 8'h01, 0, 0, "R5");
      // R6 compare
      run_op(7, 8'h42, 8'h42, 0, 0, "R6");
      run_op(7, 8'h10, 8'h20, 0, 0, "R6");
      // R7 rotates
      run_op(11, 8'h81, 0, 0, 0, "R7");
      run_op(12, 8'h01, 0, 0, 0, "R7");
      run_op(13, 8'h40, 0, 0, 0, "R7");
      run_op(14, 8'h02, 0, 0, 0, "R7");
      run_op(16, 0, 0, 0, 0, "R8");
      run_op(14, 8'h00, 0, 0, 0, "R7");
      // R8 complement keeps flags
      run_op(10, 8'h5A, 0, 0, 0, "R8");
      run_op(15, 0, 0, 0, 0, "R8");
      // R9 decimal adjust
      run_op(0, 8'h45, 8'h38, 0, 0, "R9");
      run_op(17, 8'h7D, 0, 0, 0, "R9");
      run_op(0, 8'h09, 8'h09, 0, 0, "R9");
      run_op(17, 8'h12, 0, 0, 0, "R9");
      run_op(0, 8'h99, 8'h99, 0, 0, "R9");
      run_op(17, 8'h32, 0, 0, 0, "R9");
      run_op(2, 8'h01, 8'h01, 0, 0, "R9");
      run_op(17, 8'h9B, 0, 0, 0, "R9");
      run_op(17, 8'hFA, 0, 0, 0, "R9");
      // R10 pair add
      run_op(2, 8'h00, 8'h01, 0, 0, "R10");
      run_op(18, 0, 0, 16'hFFFF, 16'h0001, "R10");
      run_op(18, 0, 0, 16'h1234, 16'h1111, "R10");
      // R11 unassigned codes
      run_op(2, 8'h00, 8'h01, 0, 0, "R11");
      run_op(25, 8'h33, 8'h44, 0, 0, "R11");
      run_op(31, 8'hFF, 8'hFF, 0, 0, "R11");
      // R2 idle gap
      go_idle(3);
      @(posedge clk);
      #1;
      check_idle("R2");
      run_op(0, 8'h01, 8'h01, 0, 0, "R2");
      go_idle(4);
      @(posedge clk);
      #1;
      check_idle("R2");
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2: pending results actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule